// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a memory-mapped watchdog with a zero-wait-state, APB-style register bus. A 32-bit down-counter runs from a programmable reload value. When the count first reaches zero, the block raises an interrupt and starts a second period from the reload value. If software has not cleared the interrupt by the time the second period ends, and the reset function is enabled, the block drives a system reset. That reset stays high until the block itself is reset.

Software keeps the system alive by writing the interrupt-clear register, which also restarts the count. Every register write except a write to the lock register is discarded until a 32-bit key has been written to the lock register. The lock register also reports the lock state when read. Software can read the current count and both the raw and the masked interrupt state at any time, whether locked or not.

Top module: `twostage_wdog`

## Requirements
- R1: After rst_ni is released, the lock register (offset 0xC00) reads 1, the count register (0x004) reads 0xFFFFFFFF, the reload register (0x000) reads 0xFFFFFFFF, control (0x008) reads 0, and irq_o, wdog_rst_o and the raw status (0x010) are all 0.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and the register then reads 0. Writing any other value there locks the block, and it reads 1.
- R3: While the block is locked, writes to the reload, control and interrupt-clear registers have no effect, and all registers can still be read.
- R4: While control bit 0 is 1, the count falls by one on every clock.
- R5: A write to the reload register (0x000) loads the count with the written value on the same edge. With control bit 0 set, raw status bit 0 becomes 1 and the count reloads on the clock edge L+1 cycles after that write, where L is the reload value.
- R6: If raw status is still 1 when the count next reaches zero and control bit 1 is 1, wdog_rst_o asserts 2*(L+1) cycles after the reload. If control bit 1 is 0, no reset occurs and counting continues.
- R7: A write of any data to offset 0x00C clears raw status and reloads the count from the reload register on the same edge.
- R8: Masked status (0x014, bit 0) equals raw status (0x010, bit 0) ANDed with control bit 0, and irq_o follows masked status.
- R9: Once wdog_rst_o is 1, it stays 1 whatever the register writes, until rst_ni is asserted.
- R10: While control bit 0 is 0, the count holds its value and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, combinational from paddr_i |
| irq_o | output | 1 | Interrupt, equal to masked status |
| wdog_rst_o | output | 1 | Sticky system reset request |

## Verification
The embedded assertions check, on every cycle, the following properties:
- The count decrements by one while enabled and holds while disabled.
- An interrupt clear always empties raw status.
- The reset request is sticky.
- The reset request never rises unless the interrupt was already pending.
- Locked writes leave the reload and control registers unchanged.
- Writing the key opens the lock.

Only the directed scenarios can show the following:
- The exact cycle counts to the first and second expiry.
- The absence of a reset when control bit 1 is clear.
- Relocking with a wrong key.
- The behaviour of the masked status and of irq_o when control bit 0 is dropped while an interrupt is pending.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;
  localparam logic [11:0] OFS_RELOAD = 12'h000;
  localparam logic [11:0] OFS_COUNT  = 12'h004;
  localparam logic [11:0] OFS_CTRL   = 12'h008;
  localparam logic [11:0] OFS_CLEAR  = 12'h00C;
  localparam logic [11:0] OFS_RAW    = 12'h010;
  localparam logic [11:0] OFS_MASKED = 12'h014;
  localparam logic [11:0] OFS_LOCK   = 12'hC00;

  typedef struct packed {
    logic rst_en;
    logic run;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_lock.sv
module wdog_lock
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_q <= 1'b1;
    else if (wr_i) locked_q <= (wdata_i != UNLOCK_KEY);
  end

  assign locked_o = locked_q;

  AST_KEY_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == UNLOCK_KEY) |=> !locked_o); // R2
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] load_i,
  input  logic             reload_i,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             rst_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ris_o,
  output logic             sys_rst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ris_q, sys_rst_q;
  logic             expire;

  // an explicit reload on the same edge suppresses expiry
  assign expire = run_i && (cnt_q == '0) && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '1;
      ris_q     <= 1'b0;
      sys_rst_q <= 1'b0;
    end else begin
      if (reload_i)   cnt_q <= load_i;
      else if (run_i) cnt_q <= (cnt_q == '0) ? load_i : cnt_q - 1'b1;

      if (clr_i)       ris_q <= 1'b0;
      else if (expire) ris_q <= 1'b1;

      if (expire && ris_q && rst_en_i) sys_rst_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign ris_o     = ris_q;
  assign sys_rst_o = sys_rst_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !reload_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> $stable(cnt_q)); // R10
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ris_q); // R7
  AST_RST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_q |=> sys_rst_q); // R9
  AST_RST_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_q) |-> $past(ris_q)); // R6
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  logic             wr, locked, wr_lock, wr_open;
  logic             wr_reload, wr_ctrl, wr_clear;
  logic [CNT_W-1:0] reload_q, reload_d, cnt;
  wdog_ctrl_t       ctrl_q;
  logic             ris, mis;

  assign wr        = psel_i && penable_i && pwrite_i;
  assign wr_lock   = wr && (paddr_i == ADDR_W'(OFS_LOCK));
  assign wr_open   = wr && !locked;
  assign wr_reload = wr_open && (paddr_i == ADDR_W'(OFS_RELOAD));
  assign wr_ctrl   = wr_open && (paddr_i == ADDR_W'(OFS_CTRL));
  assign wr_clear  = wr_open && (paddr_i == ADDR_W'(OFS_CLEAR));
  assign reload_d  = wr_reload ? pwdata_i[CNT_W-1:0] : reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '1;
      ctrl_q   <= '0;
    end else begin
      reload_q <= reload_d;
      if (wr_ctrl) ctrl_q <= wdog_ctrl_t'(pwdata_i[1:0]);
    end
  end

  wdog_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_lock),
    .wdata_i  (pwdata_i),
    .locked_o (locked)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (reload_d),
    .reload_i  (wr_reload || wr_clear),
    .clr_i     (wr_clear),
    .run_i     (ctrl_q.run),
    .rst_en_i  (ctrl_q.rst_en),
    .cnt_o     (cnt),
    .ris_o     (ris),
    .sys_rst_o (wdog_rst_o)
  );

  assign mis   = ris && ctrl_q.run;
  assign irq_o = mis;

  always_comb begin
    prdata_o = '0;
    unique case (paddr_i)
      ADDR_W'(OFS_RELOAD): prdata_o = DATA_W'(reload_q);
      ADDR_W'(OFS_COUNT):  prdata_o = DATA_W'(cnt);
      ADDR_W'(OFS_CTRL):   prdata_o = DATA_W'(ctrl_q);
      ADDR_W'(OFS_RAW):    prdata_o = DATA_W'(ris);
      ADDR_W'(OFS_MASKED): prdata_o = DATA_W'(mis);
      ADDR_W'(OFS_LOCK):   prdata_o = DATA_W'(locked);
      default:             prdata_o = '0;
    endcase
  end

  AST_LOCKED_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && locked && !wr_lock) |=> ($stable(reload_q) && $stable(ctrl_q))); // R3
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> u_cnt.ris_o); // R8
endmodule

// File: tb/sim_twostage_wdog.sv
module sim_twostage_wdog;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq, wrst;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twostage_wdog u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .irq_o(irq), .wdog_rst_o(wrst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  // commit happens on the second posedge; returns at the following negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    paddr = a;
    #1;
    d = prdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(12'hC00, v); chk("R1 lock", v, 1);
    rd(12'h004, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R1 reload", v, 32'hFFFF_FFFF);
    rd(12'h008, v); chk("R1 ctrl", v, 0);
    rd(12'h010, v); chk("R1 raw", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst", wrst, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    wr(12'h000, 7); wr(12'h008, 3);
    rd(12'h000, v); chk("R3 reload ignored", v, 32'hFFFF_FFFF);
    rd(12'h008, v); chk("R3 ctrl ignored", v, 0);
    rd(12'h004, v); chk("R3 count still idle", v, 32'hFFFF_FFFF);
    wr(12'hC00, KEY);
    rd(12'hC00, v); chk("R2 unlocked", v, 0);
    wr(12'hC00, 1);
    rd(12'hC00, v); chk("R2 relock", v, 1);
    wr(12'h000, 9);
    rd(12'h000, v); chk("R3 reload ignored after relock", v, 32'hFFFF_FFFF);
    wr(12'hC00, KEY ^ 32'h1);
    rd(12'hC00, v); chk("R2 near key stays locked", v, 1);
  endtask

  task automatic t_count_run_stop();
    logic [31:0] v;
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, 100);
    rd(12'h004, v); chk("R5 immediate reload", v, 100);
    idle(3);
    rd(12'h004, v); chk("R10 hold while off", v, 100);
    wr(12'h008, 1);
    idle(4);
    rd(12'h004, v); chk("R4 decrement", v, 96);
    wr(12'h008, 0);
    rd(12'h004, v); chk("R4 count at stop", v, 94);
    idle(5);
    rd(12'h004, v); chk("R10 stopped", v, 94);
    wr(12'h000, 2);
    idle(10);
    rd(12'h010, v); chk("R10 no expiry when off", v, 0);
  endtask

  task automatic t_two_stage_reset();
    logic [31:0] v;
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h008, 3);
    wr(12'h000, 5);
    idle(5);
    rd(12'h010, v); chk("R5 raw before first expiry", v, 0);
    rd(12'h004, v); chk("R5 count at zero", v, 0);
    idle(1);
    rd(12'h010, v); chk("R5 raw at first expiry", v, 1);
    rd(12'h004, v); chk("R5 count reloaded", v, 5);
    rd(12'h014, v); chk("R8 masked set", v, 1);
    chk("R8 irq set", irq, 1);
    idle(5);
    chk("R6 no reset yet", wrst, 0);
    idle(1);
    chk("R6 reset at second expiry", wrst, 1);
    wr(12'h008, 0); wr(12'h00C, 0);
    idle(20);
    chk("R9 reset sticky", wrst, 1);
    do_reset();
    chk("R9 cleared by rst_ni", wrst, 0);
  endtask

  task automatic t_no_reset_enable();
    logic [31:0] v;
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h008, 1);
    wr(12'h000, 3);
    idle(9);
    chk("R6 no reset without enable", wrst, 0);
    rd(12'h010, v); chk("R6 raw stays set", v, 1);
    rd(12'h004, v); chk("R6 counting continues", v, 2);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h008, 3);
    wr(12'h000, 5);
    idle(6);
    rd(12'h010, v); chk("R7 raw before clear", v, 1);
    wr(12'h00C, 32'hDEAD_BEEF);
    rd(12'h010, v); chk("R7 raw cleared", v, 0);
    rd(12'h004, v); chk("R7 count reloaded", v, 5);
    idle(6);
    rd(12'h010, v); chk("R7 fresh first expiry", v, 1);
    chk("R7 no reset after clear", wrst, 0);
    wr(12'h008, 2);
    rd(12'h010, v); chk("R8 raw with run off", v, 1);
    rd(12'h014, v); chk("R8 masked with run off", v, 0);
    chk("R8 irq with run off", irq, 0);
  endtask

  task automatic t_clear_locked();
    logic [31:0] v;
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h008, 1);
    wr(12'h000, 4);
    idle(5);
    wr(12'hC00, 0);
    wr(12'h00C, 0);
    rd(12'h010, v); chk("R3 locked clear ignored", v, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_lock();
    t_count_run_stop();
    t_two_stage_reset();
    t_no_reset_enable();
    t_clear();
    t_clear_locked();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule